// File: doc/BRIEF.md
# CAN Receive Message Queue with Overrun Flag

This block queues received CAN frames between an acceptance stage and a host. Each slot stores one frame: a 32-bit identifier word, a 4-bit length code and eight data bytes kept as two 32-bit words. The low word holds bytes 0 to 3 and the high word holds bytes 4 to 7. The default depth is three slots. A chip holds two copies of the block, one for each independent receive queue. Acceptance filtering and bit-level reception happen outside the block.

The write side is a stream with `in_valid` only. A completed frame cannot be held back, so there is no ready signal and no back-pressure. A frame offered while the queue is full is dropped and the sticky `overrun` flag is set.

The read side presents the oldest frame whenever `out_valid` is high. It uses a valid/ready style: the frame stays on the outputs until the host pulses `out_release`, and that pulse is the pop. Reading the outputs alone never removes an entry. The pending count and the full flag are plain status pins. The overrun flag is cleared by pulsing `ovr_clear`.

Top module: `can_rxq`

## Requirements
- R1: After reset, `pend_count` is 0, and `out_valid`, `full` and `overrun` are all 0.
- R2: A frame offered on `in_valid` while the queue is not full, with no release in the same cycle, is stored and raises `pend_count` by 1 at the next edge. `out_valid` is high exactly when `pend_count` is not 0.
- R3: Frames leave in arrival order. While `out_valid` is high and no release is given, the head outputs hold steady. The head shows its length code and both data words (bytes 0-3 in `out_data_lo`, bytes 4-7 in `out_data_hi`) exactly as they were written.
- R4: A release pulse while `pend_count` is not 0 frees the head slot, lowers the count by 1 and moves the next frame to the outputs. A release pulse while the queue is empty has no effect.
- R5: `full` is 1 exactly when `pend_count` equals the depth (3 by default).
- R6: A frame offered while the queue is full, with no release in the same cycle, is discarded. The count and the stored frames are unchanged, and `overrun` is 1 from the next edge.
- R7: `overrun` stays 1 until a cycle with `ovr_clear` = 1. If a frame is lost in the same cycle as a clear, the flag stays set.
- R8: A write and a release in the same cycle leave `pend_count` unchanged. This holds when the queue is full: the incoming frame takes the freed slot and `overrun` is not set.
- R9: Bit 0 of `out_id` always reads 0. Bits 31:1 are passed through unchanged. In the identifier word, bits 31:21 hold a standard ID, bits 31:3 hold an extended ID, bit 2 is the extended flag and bit 1 is the remote flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A completed frame is offered this cycle |
| in_id | input | 32 | Identifier word of the offered frame |
| in_len | input | 4 | Length code of the offered frame |
| in_data_lo | input | 32 | Data bytes 0-3 of the offered frame |
| in_data_hi | input | 32 | Data bytes 4-7 of the offered frame |
| out_release | input | 1 | Frees the head slot after it has been read |
| ovr_clear | input | 1 | Clears the overrun flag |
| out_valid | output | 1 | A frame is present at the head |
| out_id | output | 32 | Identifier word of the head frame, bit 0 forced to 0 |
| out_len | output | 4 | Length code of the head frame |
| out_data_lo | output | 32 | Data bytes 0-3 of the head frame |
| out_data_hi | output | 32 | Data bytes 4-7 of the head frame |
| pend_count | output | 2 | Number of frames waiting |
| full | output | 1 | Queue holds the maximum number of frames |
| overrun | output | 1 | Sticky flag: a frame was lost |

## Verification
The bench tries the queue with several stimulus patterns, and each one separates a different kind of fault:
- A plain fill to capacity shows whether ordering and the full threshold are right.
- A write offered while full shows whether a dropped frame is counted as lost without corrupting the stored frames.
- A write and a release in the same cycle, both at partial fill and at full fill, show whether pointer and count updates race each other.
- A release while empty shows whether the count can wrap below zero.
- A lost frame in the same cycle as a clear shows which action on the flag takes priority.
- An extended identifier with bit 0 set, and a standard identifier with the remote flag set, show whether the identifier word keeps its layout and masks its reserved bit.

// File: rtl/can_rxq_pkg.sv
package can_rxq_pkg;
  localparam int ID_W   = 32;
  localparam int LEN_W  = 4;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [LEN_W-1:0]  len;
    logic [WORD_W-1:0] lo;
    logic [WORD_W-1:0] hi;
  } frame_t;
endpackage

// File: rtl/can_rxq_ctrl.sv
module can_rxq_ctrl #(
  parameter int DEPTH = 3,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic          rel_req,
  output logic          wr_en,
  output logic          lost,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic [CW-1:0] count,
  output logic          is_full
);
  logic rel_eff;

  function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign is_full = (count == CW'(DEPTH));
  assign rel_eff = rel_req && (count != '0);
  assign wr_en   = wr_req && (!is_full || rel_eff);
  assign lost    = wr_req && is_full && !rel_eff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en)   wr_ptr <= step_ptr(wr_ptr);
      if (rel_eff) rd_ptr <= step_ptr(rd_ptr);
      unique case ({wr_en, rel_eff})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/can_rxq_store.sv
module can_rxq_store
  import can_rxq_pkg::*;
#(
  parameter int DEPTH = 3,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_ptr,
  input  frame_t        wr_frame,
  input  logic [PW-1:0] rd_ptr,
  output frame_t        rd_frame
);
  frame_t slots [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        slots[g] <= '0;
      else if (wr_en && (wr_ptr == PW'(g)))
        slots[g] <= wr_frame;
    end
  end

  always_comb begin
    rd_frame = slots[0];
    for (int i = 1; i < DEPTH; i++)
      if (rd_ptr == PW'(i)) rd_frame = slots[i];
  end
endmodule

// File: rtl/can_rxq_ovr.sv
module can_rxq_ovr (
  input  logic clk,
  input  logic rst_n,
  input  logic lost,
  input  logic clear,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)     flag <= 1'b0;
    else if (lost)  flag <= 1'b1;
    else if (clear) flag <= 1'b0;
  end
endmodule

// File: rtl/can_rxq.sv
module can_rxq
  import can_rxq_pkg::*;
#(
  parameter int DEPTH = 3,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ID_W-1:0]   in_id,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [WORD_W-1:0] in_data_lo,
  input  logic [WORD_W-1:0] in_data_hi,
  input  logic              out_release,
  input  logic              ovr_clear,
  output logic              out_valid,
  output logic [ID_W-1:0]   out_id,
  output logic [LEN_W-1:0]  out_len,
  output logic [WORD_W-1:0] out_data_lo,
  output logic [WORD_W-1:0] out_data_hi,
  output logic [CW-1:0]     pend_count,
  output logic              full,
  output logic              overrun
);
  logic          wr_en, lost;
  logic [PW-1:0] wr_ptr, rd_ptr;
  frame_t        in_frame, head;

  // reserved bit 0 of the identifier word is dropped on entry
  assign in_frame = '{id: in_id & ~ID_W'(1), len: in_len, lo: in_data_lo, hi: in_data_hi};

  can_rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_req(in_valid), .rel_req(out_release),
    .wr_en(wr_en), .lost(lost), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .count(pend_count), .is_full(full)
  );

  can_rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ptr(wr_ptr),
    .wr_frame(in_frame), .rd_ptr(rd_ptr), .rd_frame(head)
  );

  can_rxq_ovr u_ovr (
    .clk(clk), .rst_n(rst_n), .lost(lost), .clear(ovr_clear), .flag(overrun)
  );

  assign out_valid   = (pend_count != '0);
  assign out_id      = head.id;
  assign out_len     = head.len;
  assign out_data_lo = head.lo;
  assign out_data_hi = head.hi;
endmodule

// File: rtl/can_rxq_chk.sv
module can_rxq_chk #(
  parameter int DEPTH = 3,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          out_release,
  input logic          ovr_clear,
  input logic          out_valid,
  input logic [31:0]   out_id,
  input logic [3:0]    out_len,
  input logic [31:0]   out_data_lo,
  input logic [31:0]   out_data_hi,
  input logic [CW-1:0] pend_count,
  input logic          full,
  input logic          overrun
);
  assert_valid_tracks_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == (pend_count != '0));

  assert_count_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !full && !out_release |=> pend_count == $past(pend_count) + CW'(1));

  assert_head_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_release |=> $stable(out_id) && $stable(out_len)
      && $stable(out_data_lo) && $stable(out_data_hi));

  assert_release_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_release && (pend_count != '0) && !in_valid |=> pend_count == $past(pend_count) - CW'(1));

  assert_empty_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_release && (pend_count == '0) && !in_valid |=> pend_count == '0);

  assert_full_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    full == (pend_count == CW'(DEPTH)));

  assert_overrun_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && full && !out_release |=> overrun && $stable(pend_count));

  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !ovr_clear |=> overrun);

  assert_same_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && out_release && (pend_count != '0) |=> $stable(pend_count));

  assert_id_bit0_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_id[0] == 1'b0);
endmodule

bind can_rxq can_rxq_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/can_rxq_bench.sv
module can_rxq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, out_release = 1'b0, ovr_clear = 1'b0;
  logic [31:0] in_id = '0, in_data_lo = '0, in_data_hi = '0;
  logic [3:0]  in_len = '0;
  logic        out_valid, full, overrun;
  logic [31:0] out_id, out_data_lo, out_data_hi;
  logic [3:0]  out_len;
  logic [1:0]  pend_count;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk; // 250 MHz

  can_rxq u_can_rxq (.*);

  typedef struct packed {
    logic        wr, rel, clr;
    logic [31:0] id;
    logic [1:0]  cnt;
    logic        fl, ovr;
    logic [31:0] head;
  } vec_t;

  // A..F: std1, std2+remote, std 0x3FF, std8 (lost), std5, extended+remote with bit0 set
  localparam vec_t VECS [11] = '{
    '{1'b1,1'b0,1'b0,32'h0020_0000,2'd1,1'b0,1'b0,32'h0020_0000},
    '{1'b1,1'b0,1'b0,32'h0040_0002,2'd2,1'b0,1'b0,32'h0020_0000},
    '{1'b1,1'b0,1'b0,32'h7FE0_0000,2'd3,1'b1,1'b0,32'h0020_0000},
    '{1'b1,1'b0,1'b0,32'h0100_0000,2'd3,1'b1,1'b1,32'h0020_0000},
    '{1'b0,1'b1,1'b0,32'h0,        2'd2,1'b0,1'b1,32'h0040_0002},
    '{1'b1,1'b1,1'b0,32'h00A0_0000,2'd2,1'b0,1'b1,32'h7FE0_0000},
    '{1'b0,1'b0,1'b1,32'h0,        2'd2,1'b0,1'b0,32'h7FE0_0000},
    '{1'b0,1'b1,1'b0,32'h0,        2'd1,1'b0,1'b0,32'h00A0_0000},
    '{1'b0,1'b1,1'b0,32'h0,        2'd0,1'b0,1'b0,32'h0},
    '{1'b0,1'b1,1'b0,32'h0,        2'd0,1'b0,1'b0,32'h0},
    '{1'b1,1'b0,1'b0,32'h0D5E_6F7F,2'd1,1'b0,1'b0,32'h0D5E_6F7E}
  };

  function automatic logic [31:0] lo_of(input logic [31:0] id);
    return (id & ~32'h1) ^ 32'h0302_0100;
  endfunction
  function automatic logic [31:0] hi_of(input logic [31:0] id);
    return (id & ~32'h1) ^ 32'h0706_0504;
  endfunction
  function automatic logic [3:0] len_of(input logic [31:0] id);
    return id[24:21] ^ id[6:3];
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic step(input logic wr, input logic rel, input logic clr, input logic [31:0] id);
    in_valid = wr; out_release = rel; ovr_clear = clr;
    in_id = id; in_len = len_of(id); in_data_lo = lo_of(id); in_data_hi = hi_of(id);
    @(posedge clk); #1;
    in_valid = 0; out_release = 0; ovr_clear = 0;
  endtask

  task automatic chk_head(input string req, input logic [31:0] h);
    chk(req, "out_valid", {31'b0, out_valid}, 32'd1);
    chk(req, "out_id", out_id, h);
    chk(req, "out_len", {28'b0, out_len}, {28'b0, len_of(h)});
    chk(req, "out_data_lo", out_data_lo, lo_of(h));
    chk(req, "out_data_hi", out_data_hi, hi_of(h));
  endtask

  task automatic chk_status(input string req, input logic [1:0] c, input logic f, input logic o);
    chk(req, "pend_count", {30'b0, pend_count}, {30'b0, c});
    chk(req, "full", {31'b0, full}, {31'b0, f});
    chk(req, "overrun", {31'b0, overrun}, {31'b0, o});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk_status("R1", 2'd0, 1'b0, 1'b0);
    chk("R1", "out_valid", {31'b0, out_valid}, 32'd0);
    rst_n = 1; @(posedge clk); #1;

    // table: fill (R2,R5), drop when full (R6), order (R3), release (R4),
    // same-cycle write+release (R8), clear (R7), empty release (R4), id layout (R9)
    foreach (VECS[i]) begin
      step(VECS[i].wr, VECS[i].rel, VECS[i].clr, VECS[i].id);
      chk_status("R2/R4/R5/R6/R7/R8", VECS[i].cnt, VECS[i].fl, VECS[i].ovr);
      if (VECS[i].cnt != 0) chk_head("R3/R9", VECS[i].head);
      else chk("R2", "out_valid", {31'b0, out_valid}, 32'd0);
    end

    // directed: fill to full behind F
    step(1, 0, 0, 32'h1230_0000);
    step(1, 0, 0, 32'h0060_0000);
    chk_status("R5", 2'd3, 1'b1, 1'b0);
    // lost frame and clear in the same cycle: set wins
    step(1, 0, 1, 32'h0080_0000);
    chk_status("R7", 2'd3, 1'b1, 1'b1);
    chk_head("R6", 32'h0D5E_6F7E);
    step(0, 0, 1, 32'h0);
    chk_status("R7", 2'd3, 1'b1, 1'b0);
    // write and release at full: count kept, no overrun
    step(1, 1, 0, 32'h00C0_0004);
    chk_status("R8", 2'd3, 1'b1, 1'b0);
    chk_head("R8", 32'h1230_0000);
    step(0, 1, 0, 32'h0);
    chk_head("R3", 32'h0060_0000);
    step(0, 1, 0, 32'h0);
    chk_head("R8", 32'h00C0_0004);
    step(0, 1, 0, 32'h0);
    chk_status("R4", 2'd0, 1'b0, 1'b0);

    // reset mid-operation
    step(1, 0, 0, 32'h0020_0000);
    step(1, 0, 0, 32'h0040_0000);
    rst_n = 0; @(posedge clk); #1;
    chk_status("R1", 2'd0, 1'b0, 1'b0);
    chk("R1", "out_valid", {31'b0, out_valid}, 32'd0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule